// File: doc/BRIEF.md
# Fractional-N delta-sigma modulator

This block produces the division ratio that a fractional-N PLL feedback divider applies on each phase-detector cycle. A fixed integer part is offset by a small signed correction from a cascade of up to three first-order accumulators (MASH 1-1-1). Over many cycles the corrections average to the fraction NUM/DEN. A downstream multi-modulus divider consumes the registered divide value one cycle at a time. The block's clock is the phase-detector clock.

Two complete settings, A and B, are held at the inputs. Each has its own integer part, numerator, denominator and modulator order. A select input chooses the active one. Switching settings restarts the modulator from a clean state. A denominator of zero means the full modulus 2^24. An optional one-LSB pseudo-random dither can be added into the first accumulator to break up idle tones.

Top module: `fracn_dsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next `div_o` and `corr_o` are 0. Accumulators and the carry history are cleared, and the dither generator is reseeded to 1.
- R2: The numerator of a setting is {num_hi[7:0], num_lo[15:0]} and the denominator is {den_hi[7:0], den_lo[15:0]}. The modulus is the denominator, or 2^24 when the denominator is 0. Example: NUM = 2^23 with DEN = 0 and order 1 gives corrections 0,1,0,1,... Example: NUM = {1,0}, DEN = {2,0} gives the same pattern.
- R3: Order code 0 selects integer mode. `corr_o` is 0 and `div_o` equals the integer part every cycle.
- R4: Order code 1 uses one accumulator and `corr_o` is its carry (0 or 1). Any DEN consecutive outputs sum to exactly Nint·DEN + NUM. With NUM = 3 and DEN = 7, the corrections from the first output after a clear are 0,0,1,0,1,0,1.
- R5: Order code 2 gives correction c1 + c2 − c2(previous cycle), which lies in −1..2. Any DEN consecutive outputs sum to within ±1 of Nint·DEN + NUM.
- R6: Order code 3 adds c3 − 2·c3(previous) + c3(two cycles back), so the correction lies in −3..4. Any DEN consecutive outputs sum to within ±3 of Nint·DEN + NUM.
- R7: The outputs are registered and update on every clock. `div_o` equals the active integer part plus `corr_o`.
- R8: `sel_i` = 0 makes setting A active and 1 makes setting B active. At the edge where `sel_i` differs from the previously active setting, all accumulator and carry-history state clears. On that edge `div_o` becomes the new integer part with `corr_o` = 0. The outputs that follow equal those after a reset with that setting.
- R9: With `dither_en_i` low nothing is injected. With NUM = 0, `div_o` stays at the integer part indefinitely.
- R10: With `dither_en_i` high, the bit of a 23-bit maximal LFSR (x^23 + x^18 + 1) is added to the first accumulator's input. With NUM = 0, DEN = 16 and order 1, corrections are only 0 or 1, and at least one 1 appears within 256 outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-detector clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Active setting: 0 = A, 1 = B |
| dither_en_i | input | 1 | Enables LFSR dither into the first accumulator |
| a_nint_i | input | 16 | Setting A integer part |
| a_num_hi_i | input | 8 | Setting A numerator bits 23:16 |
| a_num_lo_i | input | 16 | Setting A numerator bits 15:0 |
| a_den_hi_i | input | 8 | Setting A denominator bits 23:16 |
| a_den_lo_i | input | 16 | Setting A denominator bits 15:0 |
| a_order_i | input | 2 | Setting A order code (0 integer, 1..3 order) |
| b_nint_i | input | 16 | Setting B integer part |
| b_num_hi_i | input | 8 | Setting B numerator bits 23:16 |
| b_num_lo_i | input | 16 | Setting B numerator bits 15:0 |
| b_den_hi_i | input | 8 | Setting B denominator bits 23:16 |
| b_den_lo_i | input | 16 | Setting B denominator bits 15:0 |
| b_order_i | input | 2 | Setting B order code |
| div_o | output | 18 | Signed instantaneous divide value |
| corr_o | output | 4 | Signed correction added to the integer part |

## Verification
The assertions take for granted that the active numerator is below the modulus. They also assume a setting's fields change only while that setting is inactive or under reset, so an accumulator never holds a value at or above the current modulus. The stimulus loads each setting before reset or before selecting it, and uses only numerators smaller than their denominators. Dither is toggled only ahead of a reset.

// File: rtl/fracn_dsm_pkg.sv
package fracn_dsm_pkg;

  localparam int CORR_W = 4;

  typedef enum logic [1:0] {
    ORD_INT = 2'd0,
    ORD_1   = 2'd1,
    ORD_2   = 2'd2,
    ORD_3   = 2'd3
  } dsm_order_e;

  // Combines the stage carries into the MASH 1-1-1 correction.
  function automatic logic signed [CORR_W-1:0] mash_corr(
    input dsm_order_e ord,
    input logic c1,
    input logic c2,
    input logic c2_d1,
    input logic c3,
    input logic c3_d1,
    input logic c3_d2
  );
    logic signed [CORR_W-1:0] t1, t2, t3;
    t1 = $signed({3'b000, c1});
    t2 = $signed({3'b000, c2}) - $signed({3'b000, c2_d1});
    t3 = $signed({3'b000, c3}) - $signed({2'b00, c3_d1, 1'b0}) + $signed({3'b000, c3_d2});
    case (ord)
      ORD_INT: mash_corr = '0;
      ORD_1:   mash_corr = t1;
      ORD_2:   mash_corr = t1 + t2;
      default: mash_corr = t1 + t2 + t3;
    endcase
  endfunction

endpackage

// File: rtl/fracn_dsm_setmux.sv
module fracn_dsm_setmux #(
  parameter int NINT_W = 16,
  parameter int ACC_W  = 24,
  parameter int LO_W   = 16
) (
  input  logic                    sel_i,
  input  logic [NINT_W-1:0]       a_nint_i,
  input  logic [ACC_W-LO_W-1:0]   a_num_hi_i,
  input  logic [LO_W-1:0]         a_num_lo_i,
  input  logic [ACC_W-LO_W-1:0]   a_den_hi_i,
  input  logic [LO_W-1:0]         a_den_lo_i,
  input  logic [1:0]              a_order_i,
  input  logic [NINT_W-1:0]       b_nint_i,
  input  logic [ACC_W-LO_W-1:0]   b_num_hi_i,
  input  logic [LO_W-1:0]         b_num_lo_i,
  input  logic [ACC_W-LO_W-1:0]   b_den_hi_i,
  input  logic [LO_W-1:0]         b_den_lo_i,
  input  logic [1:0]              b_order_i,
  output logic [NINT_W-1:0]       nint_o,
  output logic [ACC_W-1:0]        num_o,
  output logic [ACC_W:0]          mod_o,
  output logic [1:0]              order_o
);

  localparam int NSETS = 2;

  logic [NSETS-1:0][NINT_W-1:0] nint_s;
  logic [NSETS-1:0][ACC_W-1:0]  num_s;
  logic [NSETS-1:0][ACC_W-1:0]  den_s;
  logic [NSETS-1:0][1:0]        ord_s;
  logic [ACC_W-1:0]             den_sel;

  assign nint_s[0] = a_nint_i;
  assign nint_s[1] = b_nint_i;
  assign num_s[0]  = {a_num_hi_i, a_num_lo_i};
  assign num_s[1]  = {b_num_hi_i, b_num_lo_i};
  assign den_s[0]  = {a_den_hi_i, a_den_lo_i};
  assign den_s[1]  = {b_den_hi_i, b_den_lo_i};
  assign ord_s[0]  = a_order_i;
  assign ord_s[1]  = b_order_i;

  assign nint_o  = nint_s[sel_i];
  assign num_o   = num_s[sel_i];
  assign den_sel = den_s[sel_i];
  assign order_o = ord_s[sel_i];

  // A zero denominator stands for the full power-of-two modulus.
  assign mod_o = (den_sel == '0) ? {1'b1, {ACC_W{1'b0}}} : {1'b0, den_sel};

endmodule

// File: rtl/fracn_dsm_stage.sv
module fracn_dsm_stage #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [ACC_W:0]   mod_i,
  input  logic [ACC_W:0]   addend_i,
  output logic             carry_o,
  output logic [ACC_W-1:0] acc_nxt_o,
  output logic [ACC_W-1:0] acc_q_o
);

  logic [ACC_W:0] sum;
  logic [ACC_W:0] wrapped;

  assign sum     = {1'b0, acc_q_o} + addend_i;
  assign carry_o = (sum >= mod_i);
  assign wrapped = carry_o ? (sum - mod_i) : sum;
  assign acc_nxt_o = wrapped[ACC_W-1:0];

  always_ff @(posedge clk) begin
    if (clr) acc_q_o <= '0;
    else     acc_q_o <= acc_nxt_o;
  end

endmodule

// File: rtl/fracn_dsm_lfsr.sv
module fracn_dsm_lfsr #(
  parameter int W   = 23,
  parameter int TAP = 18
) (
  input  logic clk,
  input  logic rst,
  output logic bit_o
);

  logic [W-1:0] q;
  logic         fb;

  assign fb    = q[W-1] ^ q[TAP-1];
  assign bit_o = q[0];

  always_ff @(posedge clk) begin
    if (rst) q <= {{(W-1){1'b0}}, 1'b1};
    else     q <= {q[W-2:0], fb};
  end

endmodule

// File: rtl/fracn_dsm.sv
module fracn_dsm
  import fracn_dsm_pkg::*;
#(
  parameter int NINT_W   = 16,
  parameter int ACC_W    = 24,
  parameter int LO_W     = 16,
  parameter int LFSR_W   = 23,
  parameter int LFSR_TAP = 18
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sel_i,
  input  logic                       dither_en_i,
  input  logic [NINT_W-1:0]          a_nint_i,
  input  logic [ACC_W-LO_W-1:0]      a_num_hi_i,
  input  logic [LO_W-1:0]            a_num_lo_i,
  input  logic [ACC_W-LO_W-1:0]      a_den_hi_i,
  input  logic [LO_W-1:0]            a_den_lo_i,
  input  logic [1:0]                 a_order_i,
  input  logic [NINT_W-1:0]          b_nint_i,
  input  logic [ACC_W-LO_W-1:0]      b_num_hi_i,
  input  logic [LO_W-1:0]            b_num_lo_i,
  input  logic [ACC_W-LO_W-1:0]      b_den_hi_i,
  input  logic [LO_W-1:0]            b_den_lo_i,
  input  logic [1:0]                 b_order_i,
  output logic signed [NINT_W+1:0]   div_o,
  output logic signed [CORR_W-1:0]   corr_o
);

  localparam int STAGES = 3;
  localparam int DIV_W  = NINT_W + 2;

  // Active setting after the select mux.
  logic [NINT_W-1:0] act_nint;
  logic [ACC_W-1:0]  act_num;
  logic [ACC_W:0]    act_mod;
  logic [1:0]        act_order;

  // Named internal events for the checker.
  logic sel_q;
  logic sw_evt;
  logic clr;
  logic dith_bit;
  logic lfsr_bit;

  logic [STAGES-1:0][ACC_W:0]   addend;
  logic [STAGES-1:0][ACC_W-1:0] acc_nxt;
  logic [STAGES-1:0][ACC_W-1:0] acc_q;
  logic [STAGES-1:0]            carry;

  logic c2_d1, c3_d1, c3_d2;
  logic signed [CORR_W-1:0] corr_now;
  logic signed [DIV_W-1:0]  div_now;

  fracn_dsm_setmux #(.NINT_W(NINT_W), .ACC_W(ACC_W), .LO_W(LO_W)) u_mux (
    .sel_i      (sel_i),
    .a_nint_i   (a_nint_i),
    .a_num_hi_i (a_num_hi_i),
    .a_num_lo_i (a_num_lo_i),
    .a_den_hi_i (a_den_hi_i),
    .a_den_lo_i (a_den_lo_i),
    .a_order_i  (a_order_i),
    .b_nint_i   (b_nint_i),
    .b_num_hi_i (b_num_hi_i),
    .b_num_lo_i (b_num_lo_i),
    .b_den_hi_i (b_den_hi_i),
    .b_den_lo_i (b_den_lo_i),
    .b_order_i  (b_order_i),
    .nint_o     (act_nint),
    .num_o      (act_num),
    .mod_o      (act_mod),
    .order_o    (act_order)
  );

  fracn_dsm_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .bit_o (lfsr_bit)
  );

  assign sw_evt   = (sel_i != sel_q);
  assign clr      = rst | sw_evt;
  assign dith_bit = dither_en_i & lfsr_bit;

  assign addend[0] = {1'b0, act_num} + {{ACC_W{1'b0}}, dith_bit};

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k > 0) begin : g_feed
      assign addend[k] = {1'b0, acc_nxt[k-1]};
    end
    fracn_dsm_stage #(.ACC_W(ACC_W)) u_stage (
      .clk       (clk),
      .clr       (clr),
      .mod_i     (act_mod),
      .addend_i  (addend[k]),
      .carry_o   (carry[k]),
      .acc_nxt_o (acc_nxt[k]),
      .acc_q_o   (acc_q[k])
    );
  end

  assign corr_now = mash_corr(dsm_order_e'(act_order), carry[0], carry[1], c2_d1,
                              carry[2], c3_d1, c3_d2);
  assign div_now  = $signed({2'b00, act_nint}) +
                    $signed({{(DIV_W-CORR_W){corr_now[CORR_W-1]}}, corr_now});

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= sel_i;
      c2_d1  <= 1'b0;
      c3_d1  <= 1'b0;
      c3_d2  <= 1'b0;
      corr_o <= '0;
      div_o  <= '0;
    end else if (sw_evt) begin
      sel_q  <= sel_i;
      c2_d1  <= 1'b0;
      c3_d1  <= 1'b0;
      c3_d2  <= 1'b0;
      corr_o <= '0;
      div_o  <= $signed({2'b00, act_nint});
    end else begin
      c2_d1  <= carry[1];
      c3_d1  <= carry[2];
      c3_d2  <= c3_d1;
      corr_o <= corr_now;
      div_o  <= div_now;
    end
  end

endmodule

// File: rtl/fracn_dsm_chk.sv
module fracn_dsm_chk #(
  parameter int NINT_W = 16,
  parameter int ACC_W  = 24,
  parameter int STAGES = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         sw_evt,
  input logic                         dither_en_i,
  input logic [1:0]                   act_order,
  input logic [NINT_W-1:0]            act_nint,
  input logic [ACC_W-1:0]             act_num,
  input logic [ACC_W:0]               act_mod,
  input logic [STAGES-1:0][ACC_W-1:0] acc_q,
  input logic                         c1,
  input logic signed [NINT_W+1:0]     div_o,
  input logic signed [3:0]            corr_o
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (div_o == '0 && corr_o == '0));

  a_r6_corr_range: assert property (@(posedge clk) disable iff (rst)
    (corr_o >= -4'sd3 && corr_o <= 4'sd4));

  a_r4_order1_binary: assert property (@(posedge clk) disable iff (rst)
    (!sw_evt && act_order == 2'd1) |=> (corr_o == 4'sd0 || corr_o == 4'sd1));

  a_r5_order2_range: assert property (@(posedge clk) disable iff (rst)
    (!sw_evt && act_order == 2'd2) |=> (corr_o >= -4'sd1 && corr_o <= 4'sd2));

  a_r3_integer_mode: assert property (@(posedge clk) disable iff (rst)
    (!sw_evt && act_order == 2'd0) |=> (corr_o == 4'sd0));

  a_r8_switch_restart: assert property (@(posedge clk) disable iff (rst)
    sw_evt |=> (corr_o == 4'sd0 && div_o == $signed({2'b00, $past(act_nint)})));

  a_r2_acc_below_modulus: assert property (@(posedge clk) disable iff (rst)
    !sw_evt |-> (acc_q[0] < act_mod && acc_q[1] < act_mod && acc_q[2] < act_mod));

  a_r9_no_carry_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!sw_evt && !dither_en_i && act_num == '0) |-> !c1);

endmodule

bind fracn_dsm fracn_dsm_chk #(.NINT_W(NINT_W), .ACC_W(ACC_W), .STAGES(STAGES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sw_evt      (sw_evt),
  .dither_en_i (dither_en_i),
  .act_order   (act_order),
  .act_nint    (act_nint),
  .act_num     (act_num),
  .act_mod     (act_mod),
  .acc_q       (acc_q),
  .c1          (carry[0]),
  .div_o       (div_o),
  .corr_o      (corr_o)
);

// File: tb/tb_fracn_dsm.sv
`timescale 1ns/1ps
module tb_fracn_dsm;

  typedef struct packed {
    logic [1:0]  ord;
    logic [15:0] nint;
    logic [23:0] num;
    logic [23:0] den;
  } vec_t;

  localparam int NVEC = 7;
  localparam int RUNLEN = 64;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 16'd21,  24'd3,  24'd7},
    '{2'd1, 16'd100, 24'd9,  24'd10},
    '{2'd2, 16'd50,  24'd5,  24'd13},
    '{2'd3, 16'd22,  24'd5,  24'd13},
    '{2'd3, 16'd30,  24'd17, 24'd31},
    '{2'd2, 16'd7,   24'd1,  24'd9},
    '{2'd0, 16'd40,  24'd6,  24'd11}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic dith = 1'b0;
  logic [15:0] a_nint = '0, b_nint = '0;
  logic [7:0]  a_num_hi = '0, a_den_hi = '0, b_num_hi = '0, b_den_hi = '0;
  logic [15:0] a_num_lo = '0, a_den_lo = '0, b_num_lo = '0, b_den_lo = '0;
  logic [1:0]  a_ord = '0, b_ord = '0;
  logic signed [17:0] div_o;
  logic signed [3:0]  corr_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fracn_dsm dut (
    .clk(clk), .rst(rst), .sel_i(sel), .dither_en_i(dith),
    .a_nint_i(a_nint), .a_num_hi_i(a_num_hi), .a_num_lo_i(a_num_lo),
    .a_den_hi_i(a_den_hi), .a_den_lo_i(a_den_lo), .a_order_i(a_ord),
    .b_nint_i(b_nint), .b_num_hi_i(b_num_hi), .b_num_lo_i(b_num_lo),
    .b_den_hi_i(b_den_hi), .b_den_lo_i(b_den_lo), .b_order_i(b_ord),
    .div_o(div_o), .corr_o(corr_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load_set(input bit which, input vec_t v);
    if (!which) begin
      a_nint = v.nint; a_num_hi = v.num[23:16]; a_num_lo = v.num[15:0];
      a_den_hi = v.den[23:16]; a_den_lo = v.den[15:0]; a_ord = v.ord;
    end else begin
      b_nint = v.nint; b_num_hi = v.num[23:16]; b_num_lo = v.num[15:0];
      b_den_hi = v.den[23:16]; b_den_lo = v.den[15:0]; b_ord = v.ord;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    check(div_o == 0 && corr_o == 0, "R1 reset output", int'(div_o), 0);
    rst = 1'b0;
  endtask

  function automatic int lo_bound(input logic [1:0] o);
    case (o) 2'd0: return 0; 2'd1: return 0; 2'd2: return -1; default: return -3; endcase
  endfunction

  function automatic int hi_bound(input logic [1:0] o);
    case (o) 2'd0: return 0; 2'd1: return 1; 2'd2: return 2; default: return 4; endcase
  endfunction

  function automatic int win_tol(input logic [1:0] o);
    case (o) 2'd2: return 1; 2'd3: return 3; default: return 0; endcase
  endfunction

  function automatic string ord_req(input logic [1:0] o);
    case (o) 2'd0: return "R3"; 2'd1: return "R4"; 2'd2: return "R5"; default: return "R6"; endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    int outs [RUNLEN];
    int seq_b [20];
    vec_t v;
    int sum, exp, tol, ones, bad;

    // Table walk: sliding-window sums, correction range and div/corr agreement.
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      load_set(1'b0, v);
      sel = 1'b0;
      dith = 1'b0;
      do_reset();
      for (int t = 0; t < RUNLEN; t++) begin
        step();
        outs[t] = int'(div_o);
        check(int'(div_o) == int'(v.nint) + int'(corr_o), "R7 div equals nint plus corr",
              int'(div_o), int'(v.nint) + int'(corr_o));
        check(int'(corr_o) >= lo_bound(v.ord) && int'(corr_o) <= hi_bound(v.ord),
              ord_req(v.ord), int'(corr_o), hi_bound(v.ord));
      end
      tol = win_tol(v.ord);
      exp = int'(v.nint) * int'(v.den) + ((v.ord == 2'd0) ? 0 : int'(v.num));
      for (int s = 0; s + int'(v.den) <= RUNLEN; s++) begin
        sum = 0;
        for (int k = 0; k < int'(v.den); k++) sum += outs[s + k];
        check(sum >= exp - tol && sum <= exp + tol, ord_req(v.ord), sum, exp);
      end
    end

    // R4: exact carry order for 3/7.
    load_set(1'b0, '{2'd1, 16'd21, 24'd3, 24'd7});
    do_reset();
    begin
      int pat [7] = '{0, 0, 1, 0, 1, 0, 1};
      for (int t = 0; t < 7; t++) begin
        step();
        check(int'(corr_o) == pat[t], "R4 carry sequence", int'(corr_o), pat[t]);
      end
    end

    // R2: zero denominator means modulus 2^24.
    load_set(1'b0, '{2'd1, 16'd9, 24'h800000, 24'd0});
    do_reset();
    for (int t = 0; t < 8; t++) begin
      step();
      check(int'(div_o) == 9 + (t % 2), "R2 zero denominator", int'(div_o), 9 + (t % 2));
    end

    // R2: high and low fields placed at bits 23:16 and 15:0.
    load_set(1'b0, '{2'd1, 16'd12, 24'h010000, 24'h020000});
    do_reset();
    for (int t = 0; t < 6; t++) begin
      step();
      check(int'(div_o) == 12 + (t % 2), "R2 field split", int'(div_o), 12 + (t % 2));
    end

    // R8: setting switch restarts the modulator.
    load_set(1'b0, '{2'd1, 16'd21, 24'd3, 24'd7});
    load_set(1'b1, '{2'd3, 16'd22, 24'd5, 24'd13});
    sel = 1'b1;
    do_reset();
    for (int t = 0; t < 20; t++) begin
      step();
      seq_b[t] = int'(div_o);
    end
    sel = 1'b0;
    do_reset();
    for (int t = 0; t < 10; t++) step();
    check(int'(div_o) >= 21 && int'(div_o) <= 22, "R8 setting A active", int'(div_o), 21);
    sel = 1'b1;
    step();
    check(int'(div_o) == 22 && corr_o == 0, "R8 switch edge output", int'(div_o), 22);
    bad = 0;
    for (int t = 0; t < 20; t++) begin
      step();
      if (int'(div_o) != seq_b[t]) bad++;
    end
    check(bad == 0, "R8 sequence after switch", bad, 0);

    // R9: no dither, zero numerator holds the integer part.
    load_set(1'b0, '{2'd1, 16'd33, 24'd0, 24'd16});
    sel = 1'b0;
    dith = 1'b0;
    do_reset();
    bad = 0;
    for (int t = 0; t < 64; t++) begin
      step();
      if (int'(div_o) != 33) bad++;
    end
    check(bad == 0, "R9 dither off no injection", bad, 0);

    // R10: dither on injects occasional carries.
    dith = 1'b1;
    do_reset();
    bad = 0;
    ones = 0;
    for (int t = 0; t < 256; t++) begin
      step();
      if (int'(div_o) == 34) ones++;
      else if (int'(div_o) != 33) bad++;
    end
    check(bad == 0, "R10 dither correction range", bad, 0);
    check(ones > 0, "R10 dither produces carries", ones, 1);
    dith = 1'b0;

    // R1: reset after activity clears output again.
    do_reset();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule